// File: doc/BRIEF.md
# Time-Windowed Write-Once Configuration Register

This block holds two static startup settings for a small microcontroller-style bus. The first is a watchdog-off bit and the second is an on-chip ROM mapping bit. It sits in the register block at offset 0x3F. Bus reads of that offset return the latched settings. Bus writes are filtered by a protection gate.

In normal operating mode the gate opens only for a fixed number of bus cycles after reset. Within that window it accepts a single write, and then it locks until the next reset. In special mode the gate is bypassed, so the register may be rewritten at any time. Special-mode writes do not consume the single normal-mode write. If the mode input drops from special to normal, the remaining window and the lock apply from that cycle on.

The bus port is a plain single-cycle register port with no back-pressure. A write strobe takes effect at the clock edge where it is sampled, and read data is combinational from the address. The bus-cycle strobe is a separate input, and each high sample of it advances the window count by one.

Top module: `cfg_lock_reg`

## Requirements
- R1: A synchronous reset sets the watchdog-off bit to 0 and the ROM bit to 1, restarts the window count and clears the lock, in either mode.
- R2: Only accesses with address 0x3F reach the register. A write to any other address changes nothing and does not consume the lock. A read of any other address returns 0.
- R3: A read of 0x3F returns the watchdog-off bit at bit 2 and the ROM bit at bit 1. All other bits read 0.
- R4: In normal mode a write is accepted only while fewer than WINDOW_CYCLES bus-cycle strobes (64 by default) have been counted since reset. The count saturates and stays closed until reset.
- R5: In normal mode only the first write accepted after a reset takes effect. It locks the register even when the written value equals the current one.
- R6: In special mode every write to 0x3F is accepted at any time, regardless of window or lock, and none of them sets the lock.
- R7: After a switch from special to normal mode, the window count already reached and the lock state govern later writes. Earlier special-mode writes leave the single normal-mode write available.
- R8: wdog_en is the inverse of the watchdog-off bit, and rom_map equals the ROM bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cycle | input | 1 | One high sample per bus cycle; advances the window |
| special_mode | input | 1 | 1 = special mode (protection bypassed), 0 = normal |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (0 unless a read hits 0x3F) |
| wdog_en | output | 1 | Watchdog enable level |
| rom_map | output | 1 | ROM present in the memory map |

## Verification
The bench builds the block with its default parameters: a 64-cycle window, a 6-bit address and a 3F offset. With these values the window edge can be hit exactly. Writes after 63 strobes must land, and writes after 64 must not. A run of 200 strobes shows that the count saturates without wrapping back open. Mode switches are driven both inside and after the window, which separates the lock, the window and the special-mode bypass from one another.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int unsigned CFG_WDOG_POS = 2;
  localparam int unsigned CFG_ROM_POS  = 1;

  typedef struct packed {
    logic wdog_off;
    logic rom_on;
  } cfg_bits_t;

  localparam cfg_bits_t CFG_RESET_VAL = '{wdog_off: 1'b0, rom_on: 1'b1};
endpackage

// File: rtl/cfg_window_ctr.sv
module cfg_window_ctr #(
  parameter int unsigned WINDOW_CYCLES = 64,
  localparam int unsigned CNT_W = $clog2(WINDOW_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic open_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WINDOW_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (strobe && (cnt_q != LIMIT))
      cnt_q <= cnt_q + 1'b1;
  end

  assign open_o = (cnt_q < LIMIT);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);
  assert_window_stays_closed_R4: assert property (@(posedge clk) disable iff (rst)
    !open_o |=> !open_o);
endmodule

// File: rtl/cfg_write_gate.sv
module cfg_write_gate (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic special,
  input  logic window_open,
  output logic accept_o,
  output logic locked_o
);
  logic locked_q;
  logic normal_take;

  assign normal_take = wr_hit && !special && window_open && !locked_q;
  assign accept_o    = (wr_hit && special) || normal_take;
  assign locked_o    = locked_q;

  always_ff @(posedge clk) begin
    if (rst)
      locked_q <= 1'b0;
    else if (normal_take)
      locked_q <= 1'b1;
  end

  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> locked_q);
  assert_lock_from_normal_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_q) |-> $past(wr_hit && !special));
  assert_locked_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !special) |-> !accept_o);
  assert_special_passes_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && special) |-> accept_o);
endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  cfg_lock_pkg::cfg_bits_t load_val,
  output cfg_lock_pkg::cfg_bits_t bits_o,
  output logic [DATA_W-1:0]      image_o
);
  import cfg_lock_pkg::*;

  cfg_bits_t bits_q;

  always_ff @(posedge clk) begin
    if (rst)
      bits_q <= CFG_RESET_VAL;
    else if (load)
      bits_q <= load_val;
  end

  assign bits_o = bits_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_img
    if (i == CFG_WDOG_POS) begin : g_wdog
      assign image_o[i] = bits_q.wdog_off;
    end else if (i == CFG_ROM_POS) begin : g_rom
      assign image_o[i] = bits_q.rom_on;
    end else begin : g_zero
      assign image_o[i] = 1'b0;
    end
  end

  assert_hold_without_load_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(bits_q));
endmodule

// File: rtl/cfg_lock_reg.sv
module cfg_lock_reg #(
  parameter int unsigned WINDOW_CYCLES = 64,
  parameter int unsigned ADDR_W        = 6,
  parameter int unsigned DATA_W        = 8,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = ADDR_W'(6'h3F)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cycle,
  input  logic              special_mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wdog_en,
  output logic              rom_map
);
  import cfg_lock_pkg::*;

  localparam logic [DATA_W-1:0] IMPL_MASK =
    DATA_W'((1 << CFG_WDOG_POS) | (1 << CFG_ROM_POS));

  logic      hit;
  logic      wr_hit;
  logic      window_open;
  logic      accept;
  logic      locked;
  cfg_bits_t bits;
  cfg_bits_t new_bits;
  logic [DATA_W-1:0] image;
  logic      unused_wdata;

  assign hit    = (addr == CFG_OFFSET);
  assign wr_hit = wr_en && hit;

  assign new_bits.wdog_off = wdata[CFG_WDOG_POS];
  assign new_bits.rom_on   = wdata[CFG_ROM_POS];
  assign unused_wdata      = ^(wdata & ~IMPL_MASK);

  cfg_window_ctr #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_window (
    .clk    (clk),
    .rst    (rst),
    .strobe (bus_cycle),
    .open_o (window_open)
  );

  cfg_write_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .wr_hit      (wr_hit),
    .special     (special_mode),
    .window_open (window_open),
    .accept_o    (accept),
    .locked_o    (locked)
  );

  cfg_bit_store #(.DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (new_bits),
    .bits_o   (bits),
    .image_o  (image)
  );

  assign rdata   = (rd_en && hit) ? image : '0;
  assign wdog_en = ~bits.wdog_off;
  assign rom_map = bits.rom_on;

  assert_unimpl_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~IMPL_MASK) == '0);
  assert_miss_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !hit |-> rdata == '0);
  assert_closed_window_R4: assert property (@(posedge clk) disable iff (rst)
    (!special_mode && !window_open) |=> ($stable(wdog_en) && $stable(rom_map)));
  assert_locked_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!special_mode && locked) |=> ($stable(wdog_en) && $stable(rom_map)));
endmodule

// File: tb/test_cfg_lock_reg.sv
module test_cfg_lock_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_cycle = 1'b0;
  logic       special_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       wdog_en;
  logic       rom_map;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_lock_reg i_cfg_lock_reg (
    .clk(clk), .rst(rst), .bus_cycle(bus_cycle), .special_mode(special_mode),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .wdog_en(wdog_en), .rom_map(rom_map)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(bit spec);
    @(negedge clk);
    special_mode = spec; rst = 1'b1; bus_cycle = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic strobes(int n);
    repeat (n) begin
      @(negedge clk);
      bus_cycle = 1'b1;
    end
    @(negedge clk);
    bus_cycle = 1'b0;
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(string req, logic [5:0] a, logic [7:0] exp);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1;
    check(req, rdata, exp);
    rd_en = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b0);
    rd_check("R1", 6'h3F, 8'h02);
    check("R8 wdog_en", {7'b0, wdog_en}, 8'h01);
    check("R8 rom_map", {7'b0, rom_map}, 8'h01);
  endtask

  task automatic t_decode();
    do_reset(1'b0);
    wr(6'h3E, 8'hFF);
    rd_check("R2 miss write", 6'h3F, 8'h02);
    rd_check("R2 miss read", 6'h3E, 8'h00);
    wr(6'h3F, 8'hFF);
    rd_check("R3 unimpl zero", 6'h3F, 8'h06);
    check("R8 wdog off", {7'b0, wdog_en}, 8'h00);
    check("R8 rom on", {7'b0, rom_map}, 8'h01);
  endtask

  task automatic t_once();
    do_reset(1'b0);
    wr(6'h3F, 8'h02);
    wr(6'h3F, 8'h04);
    rd_check("R5 same-value lock", 6'h3F, 8'h02);
    do_reset(1'b0);
    wr(6'h3F, 8'h04);
    rd_check("R1 reset restarts lock", 6'h3F, 8'h04);
    check("R8 rom removed", {7'b0, rom_map}, 8'h00);
  endtask

  task automatic t_window();
    do_reset(1'b0);
    strobes(63);
    wr(6'h3F, 8'h04);
    rd_check("R4 last open cycle", 6'h3F, 8'h04);
    do_reset(1'b0);
    strobes(64);
    wr(6'h3F, 8'h04);
    rd_check("R4 window closed", 6'h3F, 8'h02);
    do_reset(1'b0);
    strobes(200);
    wr(6'h3F, 8'h04);
    rd_check("R4 saturated", 6'h3F, 8'h02);
  endtask

  task automatic t_special();
    do_reset(1'b1);
    strobes(100);
    wr(6'h3F, 8'h04);
    rd_check("R6 late write", 6'h3F, 8'h04);
    wr(6'h3F, 8'h00);
    rd_check("R6 second write", 6'h3F, 8'h00);
    wr(6'h3F, 8'h06);
    rd_check("R6 third write", 6'h3F, 8'h06);
  endtask

  task automatic t_switch();
    do_reset(1'b1);
    strobes(10);
    wr(6'h3F, 8'h04);
    @(negedge clk);
    special_mode = 1'b0;
    wr(6'h3F, 8'h00);
    rd_check("R7 normal write available", 6'h3F, 8'h00);
    wr(6'h3F, 8'h06);
    rd_check("R7 lock after switch", 6'h3F, 8'h00);
    do_reset(1'b1);
    strobes(70);
    wr(6'h3F, 8'h04);
    @(negedge clk);
    special_mode = 1'b0;
    wr(6'h3F, 8'h02);
    rd_check("R7 window already closed", 6'h3F, 8'h04);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_decode();
    t_once();
    t_window();
    t_special();
    t_switch();
    finish_run();
  end
endmodule